// File: doc/BRIEF.md
# Block I/O Transfer Step Engine

This block carries out a single iteration of a block input or block output instruction for an 8-bit processor core. The sequencer in the core decodes the instruction and pulses `start` with the operation code, the byte counter B, the port low byte C and the 16-bit memory pointer HL. The engine then runs two bus transactions in order. In an input form it reads the port and writes the byte to memory. In an output form it reads memory and writes the byte to the port. Each transaction uses a request/acknowledge handshake, and the peer may hold the acknowledge back for any number of cycles.

When the second transaction completes, the engine returns the updated B and HL, an 8-bit flag byte and a `rerun` indication. For a repeating form, `rerun` tells the core to rewind its program counter by two and issue the instruction again. A one-cycle `done` pulse marks the end of the step. The result outputs keep their values until the second transaction of the next step completes.

The operation code has three fields. Bit 0 selects the direction: 1 is output and 0 is input. Bit 1 selects the pointer direction: 1 decrements HL and 0 increments it. Bit 2 selects the repeating form.

Top module: `bio_step_engine`

## Requirements
- R1: B is returned as its start value minus one, modulo 256. A start value of 0x00 returns 0xFF.
- R2: HL is returned as its start value plus one when op bit 1 is 0, and minus one when op bit 1 is 1, modulo 65536. 0xFFFF wraps to 0x0000 and 0x0000 wraps to 0xFFFF.
- R3: In input forms (op bit 0 = 0), the port is read first at address {original B, C} with `io_we`=0. The byte is then written to memory at the original HL with `mem_we`=1.
- R4: In output forms (op bit 0 = 1), memory is read first at the original HL with `mem_we`=0. The byte is then written to the port with `io_we`=1 at address {B-1, C}, so the upper byte is the already-decremented count.
- R5: Flag bit 1 (N) equals bit 7 of the transferred byte.
- R6: Flag bit 7 (S) equals bit 7 of the new B. Flag bit 6 (Z) is 1 exactly when the new B is zero. Flag bits 5 and 3 copy the same bits of the new B. Flag bits 4, 2 and 0 (H, P/V, C) are always 0.
- R7: `rerun` is 1 only for a repeating form (op bit 2 = 1) whose new B is non-zero. Otherwise it is 0.
- R8: `done` rises one cycle after the acknowledge of the second transaction. For a repeating output form whose new B is zero, it rises TAIL_CYCLES cycles later than that (1+TAIL_CYCLES cycles after the acknowledge).
- R9: `done` lasts exactly one cycle. B, HL, flags and `rerun` keep their values after the pulse while no new step is running.
- R10: A request, together with its address and write flag, stays asserted and unchanged until acknowledged, whatever the wait count. Memory and port requests are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a step (accepted when idle) |
| op | input | 3 | {repeat, decrement, output} |
| b_in | input | 8 | Byte counter B at start |
| c_in | input | 8 | Port low byte C |
| hl_in | input | ADDR_W | Memory pointer HL at start |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid with ack |
| mem_ack | input | 1 | Memory acknowledge |
| io_req | output | 1 | Port request |
| io_we | output | 1 | Port write (1) or read (0) |
| io_addr | output | 16 | Port address {B, C} |
| io_wdata | output | 8 | Port write data |
| io_rdata | input | 8 | Port read data, valid with ack |
| io_ack | input | 1 | Port acknowledge |
| done | output | 1 | One-cycle end-of-step pulse |
| rerun | output | 1 | Repeat form must re-execute |
| b_out | output | 8 | Updated B |
| hl_out | output | ADDR_W | Updated HL |
| flags_out | output | 8 | Flag byte |

## Verification
Every result becomes valid on the same clock edge that takes the second acknowledge. `done` follows one cycle later, or TAIL_CYCLES+1 cycles later after a finished repeating output. The bench therefore counts falling edges from the edge at which its responder raised the final acknowledge to the first falling edge at which `done` is seen, and compares that count with 1 or 1+TAIL_CYCLES. The bus addresses, write flags and data are captured at the moment the responder acknowledges. The returned B, HL, flags and `rerun` are read at the `done` edge and again some cycles later. The responders insert configurable wait states so that the same checks run with zero and with long acknowledge delays.

// File: rtl/bio_pkg.sv
package bio_pkg;

    localparam int BYTE_W = 8;
    localparam int PORT_W = 2 * BYTE_W;

    typedef struct packed {
        logic rep;   // bit 2: repeating form
        logic dec;   // bit 1: pointer steps downward
        logic out;   // bit 0: memory -> port
    } bio_op_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRST,
        ST_SECOND,
        ST_TAIL,
        ST_DONE
    } bio_state_t;

    localparam int FL_S  = 7;
    localparam int FL_Z  = 6;
    localparam int FL_X5 = 5;
    localparam int FL_H  = 4;
    localparam int FL_X3 = 3;
    localparam int FL_PV = 2;
    localparam int FL_N  = 1;
    localparam int FL_C  = 0;

    function automatic logic [BYTE_W-1:0] count_next(input logic [BYTE_W-1:0] b);
        return b - BYTE_W'(1);
    endfunction

endpackage

// File: rtl/bio_flags.sv
module bio_flags
    import bio_pkg::*;
(
    input  logic [BYTE_W-1:0] new_b,
    input  logic              xfer_msb,
    output logic [7:0]        flags
);
    always_comb begin
        flags         = '0;
        flags[FL_S]   = new_b[7];
        flags[FL_Z]   = (new_b == '0);
        flags[FL_X5]  = new_b[5];
        flags[FL_X3]  = new_b[3];
        flags[FL_N]   = xfer_msb;
        flags[FL_H]   = 1'b0;
        flags[FL_PV]  = 1'b0;
        flags[FL_C]   = 1'b0;
    end
endmodule

// File: rtl/bio_seq.sv
module bio_seq
    import bio_pkg::*;
#(
    parameter int TAIL_CYCLES = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  bio_op_t    op_q,
    input  logic       newb_zero,
    input  logic       ack_first,
    input  logic       ack_second,
    output bio_state_t state,
    output logic       load,
    output logic       cap,
    output logic       commit
);
    localparam int CW        = (TAIL_CYCLES > 1) ? $clog2(TAIL_CYCLES) : 1;
    localparam int TAIL_LAST = (TAIL_CYCLES > 0) ? TAIL_CYCLES - 1 : 0;

    bio_state_t       state_n;
    logic [CW-1:0]    tail_cnt;
    logic             want_tail;

    assign load      = (state == ST_IDLE)   && start;
    assign cap       = (state == ST_FIRST)  && ack_first;
    assign commit    = (state == ST_SECOND) && ack_second;
    assign want_tail = (TAIL_CYCLES > 0) && op_q.rep && op_q.out && newb_zero;

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (start)      state_n = ST_FIRST;
            ST_FIRST:  if (ack_first)  state_n = ST_SECOND;
            ST_SECOND: if (ack_second) state_n = want_tail ? ST_TAIL : ST_DONE;
            ST_TAIL:   if (tail_cnt == CW'(TAIL_LAST)) state_n = ST_DONE;
            ST_DONE:   state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            tail_cnt <= '0;
        end else begin
            state <= state_n;
            if (state == ST_TAIL)
                tail_cnt <= tail_cnt + CW'(1);
            else
                tail_cnt <= '0;
        end
    end
endmodule

// File: rtl/bio_datapath.sv
module bio_datapath
    import bio_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              cap,
    input  logic              commit,
    input  bio_op_t           op_in,
    input  logic [BYTE_W-1:0] b_in,
    input  logic [BYTE_W-1:0] c_in,
    input  logic [ADDR_W-1:0] hl_in,
    input  logic [BYTE_W-1:0] byte_src,
    input  logic [7:0]        flags_in,
    output bio_op_t           op_q,
    output logic [BYTE_W-1:0] new_b,
    output logic [BYTE_W-1:0] byte_q,
    output logic [PORT_W-1:0] port_addr,
    output logic [ADDR_W-1:0] ptr_addr,
    output logic [BYTE_W-1:0] b_res,
    output logic [ADDR_W-1:0] hl_res,
    output logic [7:0]        flags_res,
    output logic              rerun_res
);
    logic [BYTE_W-1:0] b_q;
    logic [BYTE_W-1:0] c_q;
    logic [ADDR_W-1:0] hl_q;
    logic [ADDR_W-1:0] hl_step;

    assign new_b     = count_next(b_q);
    assign hl_step   = op_q.dec ? hl_q - ADDR_W'(1) : hl_q + ADDR_W'(1);
    assign ptr_addr  = hl_q;

    // Output forms present the already-decremented count on the port.
    assign port_addr = op_q.out ? {new_b, c_q} : {b_q, c_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q      <= '0;
            b_q       <= '0;
            c_q       <= '0;
            hl_q      <= '0;
            byte_q    <= '0;
            b_res     <= '0;
            hl_res    <= '0;
            flags_res <= '0;
            rerun_res <= 1'b0;
        end else begin
            if (load) begin
                op_q <= op_in;
                b_q  <= b_in;
                c_q  <= c_in;
                hl_q <= hl_in;
            end
            if (cap)
                byte_q <= byte_src;
            if (commit) begin
                b_res     <= new_b;
                hl_res    <= hl_step;
                flags_res <= flags_in;
                rerun_res <= op_q.rep && (new_b != '0);
            end
        end
    end
endmodule

// File: rtl/bio_step_engine.sv
module bio_step_engine
    import bio_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int TAIL_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [7:0]        b_in,
    input  logic [7:0]        c_in,
    input  logic [ADDR_W-1:0] hl_in,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ack,
    output logic              io_req,
    output logic              io_we,
    output logic [15:0]       io_addr,
    output logic [7:0]        io_wdata,
    input  logic [7:0]        io_rdata,
    input  logic              io_ack,
    output logic              done,
    output logic              rerun,
    output logic [7:0]        b_out,
    output logic [ADDR_W-1:0] hl_out,
    output logic [7:0]        flags_out
);
    bio_state_t        state;
    bio_op_t           op_q;
    logic              load, cap, commit;
    logic              ack_first, ack_second;
    logic [BYTE_W-1:0] new_b, byte_q, byte_src;
    logic [7:0]        flags_next;
    logic              in_first, in_second;

    assign in_first   = (state == ST_FIRST);
    assign in_second  = (state == ST_SECOND);
    assign ack_first  = op_q.out ? mem_ack : io_ack;
    assign ack_second = op_q.out ? io_ack  : mem_ack;
    assign byte_src   = op_q.out ? mem_rdata : io_rdata;

    // Output forms use memory first, input forms use the port first.
    assign mem_req   = (in_first && op_q.out) || (in_second && !op_q.out);
    assign io_req    = (in_first && !op_q.out) || (in_second && op_q.out);
    assign mem_we    = !op_q.out;
    assign io_we     = op_q.out;
    assign mem_wdata = byte_q;
    assign io_wdata  = byte_q;
    assign done      = (state == ST_DONE);

    bio_seq #(.TAIL_CYCLES(TAIL_CYCLES)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .op_q       (op_q),
        .newb_zero  (new_b == '0),
        .ack_first  (ack_first),
        .ack_second (ack_second),
        .state      (state),
        .load       (load),
        .cap        (cap),
        .commit     (commit)
    );

    bio_flags u_flags (
        .new_b    (new_b),
        .xfer_msb (byte_q[BYTE_W-1]),
        .flags    (flags_next)
    );

    bio_datapath #(.ADDR_W(ADDR_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .cap       (cap),
        .commit    (commit),
        .op_in     (bio_op_t'(op)),
        .b_in      (b_in),
        .c_in      (c_in),
        .hl_in     (hl_in),
        .byte_src  (byte_src),
        .flags_in  (flags_next),
        .op_q      (op_q),
        .new_b     (new_b),
        .byte_q    (byte_q),
        .port_addr (io_addr),
        .ptr_addr  (mem_addr),
        .b_res     (b_out),
        .hl_res    (hl_out),
        .flags_res (flags_out),
        .rerun_res (rerun)
    );
endmodule

// File: rtl/bio_step_engine_chk.sv
module bio_step_engine_chk #(
    parameter int ADDR_W      = 16,
    parameter int TAIL_CYCLES = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              io_req,
    input logic              io_ack,
    input logic              io_we,
    input logic [15:0]       io_addr,
    input logic              done,
    input logic              rerun,
    input logic [7:0]        b_out,
    input logic [ADDR_W-1:0] hl_out,
    input logic [7:0]        flags_out
);
    logic [15:0] since_ack;

    always_ff @(posedge clk) begin
        if (rst)
            since_ack <= 16'hFFFF;
        else if (mem_ack || io_ack)
            since_ack <= 16'd1;
        else if (since_ack != 16'hFFFF)
            since_ack <= since_ack + 16'd1;
    end

    a_r10_io_hold: assert property (@(posedge clk) disable iff (rst)
        io_req && !io_ack |=> io_req && $stable(io_addr) && $stable(io_we));

    a_r10_mem_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    a_r10_one_bus: assert property (@(posedge clk) disable iff (rst)
        !(io_req && mem_req));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_result_hold: assert property (@(posedge clk) disable iff (rst)
        done |=> $stable(b_out) && $stable(hl_out) && $stable(flags_out) && $stable(rerun));

    a_r6_zero_flag: assert property (@(posedge clk) disable iff (rst)
        done |-> (flags_out[6] == (b_out == 8'h00)) && (flags_out[4] == 1'b0)
                 && (flags_out[2] == 1'b0) && (flags_out[0] == 1'b0));

    a_r7_no_rerun_at_zero: assert property (@(posedge clk) disable iff (rst)
        done && (b_out == 8'h00) |-> !rerun);

    a_r8_done_latency: assert property (@(posedge clk) disable iff (rst)
        done |-> (since_ack == 16'd1) || (since_ack == 16'(TAIL_CYCLES + 1)));
endmodule

bind bio_step_engine bio_step_engine_chk #(
    .ADDR_W      (ADDR_W),
    .TAIL_CYCLES (TAIL_CYCLES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .io_req    (io_req),
    .io_ack    (io_ack),
    .io_we     (io_we),
    .io_addr   (io_addr),
    .done      (done),
    .rerun     (rerun),
    .b_out     (b_out),
    .hl_out    (hl_out),
    .flags_out (flags_out)
);

// File: tb/bio_step_engine_test.sv
module bio_step_engine_test;
    localparam int ADDR_W = 16;
    localparam int TAIL   = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [2:0]        op = '0;
    logic [7:0]        b_in = '0, c_in = '0;
    logic [ADDR_W-1:0] hl_in = '0;
    logic              mem_req, mem_we, io_req, io_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata, io_wdata, mem_rdata, io_rdata;
    logic [15:0]       io_addr;
    logic              mem_ack = 1'b0, io_ack = 1'b0;
    logic              done, rerun;
    logic [7:0]        b_out, flags_out;
    logic [ADDR_W-1:0] hl_out;

    int checks = 0, errors = 0;
    int mem_wait = 0, io_wait = 0, mcnt = 0, icnt = 0;
    int ncyc = 0, last_ack = 0;
    logic [7:0]  port_val = 8'h00;
    logic [15:0] m_addr = '0, i_addr = '0;
    logic        m_we = 1'b0, i_we = 1'b0;
    logic [7:0]  m_wd = '0, i_wd = '0;
    int          m_seen = 0, i_seen = 0;

    always #10 clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    assign mem_rdata = mem_byte(mem_addr);
    assign io_rdata  = port_val;

    bio_step_engine #(.ADDR_W(ADDR_W), .TAIL_CYCLES(TAIL)) uut (
        .clk(clk), .rst(rst), .start(start), .op(op), .b_in(b_in), .c_in(c_in), .hl_in(hl_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .io_req(io_req), .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_ack(io_ack),
        .done(done), .rerun(rerun), .b_out(b_out), .hl_out(hl_out), .flags_out(flags_out)
    );

    // Bus responders with programmable wait states, logging each accepted access.
    always @(negedge clk) begin
        ncyc    <= ncyc + 1;
        mem_ack <= 1'b0;
        io_ack  <= 1'b0;
        if (mem_req && !mem_ack) begin
            if (mcnt >= mem_wait) begin
                mem_ack <= 1'b1; mcnt <= 0;
                m_addr <= mem_addr; m_we <= mem_we; m_wd <= mem_wdata;
                m_seen <= m_seen + 1; last_ack <= ncyc;
            end else mcnt <= mcnt + 1;
        end
        if (io_req && !io_ack) begin
            if (icnt >= io_wait) begin
                io_ack <= 1'b1; icnt <= 0;
                i_addr <= io_addr; i_we <= io_we; i_wd <= io_wdata;
                i_seen <= i_seen + 1; last_ack <= ncyc;
            end else icnt <= icnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One step; expected values come from the requirements.
    task automatic run_step(input logic [2:0] opc, input logic [7:0] b, input logic [7:0] c,
                            input logic [15:0] hl, input int mw, input int iw,
                            input logic [7:0] pval);
        logic [7:0]  nb, xb, ef;
        logic [15:0] nhl;
        int          lat, guard, m0, i0;
        bit          outf, decf, repf;
        outf = opc[0]; decf = opc[1]; repf = opc[2];
        nb   = b - 8'd1;
        nhl  = decf ? hl - 16'd1 : hl + 16'd1;
        xb   = outf ? mem_byte(hl) : pval;
        ef   = {nb[7], (nb == 8'h00), nb[5], 1'b0, nb[3], 1'b0, xb[7], 1'b0};
        mem_wait = mw; io_wait = iw; port_val = pval;
        m0 = m_seen; i0 = i_seen;
        @(negedge clk);
        start = 1'b1; op = opc; b_in = b; c_in = c; hl_in = hl;
        @(negedge clk);
        start = 1'b0; b_in = 8'hEE; hl_in = 16'hDEAD;
        guard = 0;
        forever begin
            @(negedge clk); #1;
            if (done) break;
            guard++;
            if (guard > 500) break;
        end
        chk("R9 done seen", {31'd0, done}, 32'd1);
        lat = ncyc - last_ack - 1;
        chk("R8 done latency", lat, (repf && outf && nb == 8'h00) ? 1 + TAIL : 1);
        chk("R10 one access per bus", (m_seen - m0) * 16 + (i_seen - i0), 32'd17);
        chk("R3/R4 mem addr", m_addr, hl);
        chk("R3/R4 mem we", {31'd0, m_we}, {31'd0, !outf});
        if (outf) begin
            chk("R4 port addr uses new B", i_addr, {nb, c});
            chk("R4 port write data", i_wd, xb);
        end else begin
            chk("R3 port addr uses original B", i_addr, {b, c});
            chk("R3 mem write data", m_wd, xb);
        end
        chk("R3/R4 port we", {31'd0, i_we}, {31'd0, outf});
        chk("R1 B result", b_out, nb);
        chk("R2 HL result", hl_out, nhl);
        chk("R5/R6 flags", flags_out, ef);
        chk("R7 rerun", {31'd0, rerun}, {31'd0, repf && nb != 8'h00});
        @(negedge clk); #1;
        chk("R9 done single cycle", {31'd0, done}, 32'd0);
        repeat (4) @(negedge clk);
        #1;
        chk("R9 results held B", b_out, nb);
        chk("R9 results held HL", hl_out, nhl);
        chk("R9 results held flags", flags_out, ef);
    endtask

    task automatic t_reset;
        chk("R9 reset done", {31'd0, done}, 32'd0);
        chk("R10 reset mem_req", {31'd0, mem_req}, 32'd0);
        chk("R10 reset io_req", {31'd0, io_req}, 32'd0);
        chk("R9 reset B", b_out, 8'h00);
        chk("R9 reset rerun", {31'd0, rerun}, 32'd0);
    endtask

    task automatic t_single_in;
        run_step(3'b000, 8'h10, 8'h34, 16'h8000, 0, 0, 8'h9C);   // R3 R5
        run_step(3'b010, 8'h00, 8'h01, 16'h0000, 2, 3, 8'h11);   // R1 R2 wraps
    endtask

    task automatic t_single_out;
        run_step(3'b001, 8'h01, 8'hFE, 16'hFFFF, 1, 0, 8'h00);   // R4 R2 wrap, Z
        run_step(3'b011, 8'hA9, 8'h55, 16'h1290, 0, 4, 8'h00);   // R4 decrement
    endtask

    task automatic t_repeat_out;
        logic [7:0]  b;
        logic [15:0] hl;
        b = 8'h03; hl = 16'h4000;
        for (int k = 0; k < 3; k++) begin   // R7 R8 looping then tail
            run_step(3'b101, b, 8'h7F, hl, k, 1, 8'h00);
            b = b_out; hl = hl_out;
        end
        run_step(3'b111, 8'h01, 8'h20, 16'h0000, 3, 3, 8'h00);  // R8 tail, decrement wrap
    endtask

    task automatic t_repeat_in;
        run_step(3'b100, 8'h02, 8'h40, 16'h2000, 0, 0, 8'h80);   // R7 rerun
        run_step(3'b100, 8'h01, 8'h40, 16'h2001, 0, 0, 8'h7F);   // R8 no tail on input
        run_step(3'b110, 8'h29, 8'h01, 16'h3000, 5, 6, 8'hF0);   // R10 long waits
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        t_reset();
        t_single_in();
        t_single_out();
        t_repeat_out();
        t_repeat_in();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule